// File: doc/BRIEF.md
# Folded 19-Point Star Stencil Engine

This block streams a 3D volume of signed fixed-point samples, one sample per handshake, in raster order (x fastest, then y, then z). For each sample whose distance to every face of the volume is at least three, it produces one filtered value. The filter is an axis-aligned star of radius 3. It weights the point itself and the three nearest neighbours on each side along x, along y and along z, which gives 19 points in all.

The weights are equal for the two neighbours that sit at the same distance on the same axis. The engine therefore adds each such pair first and multiplies the sum once. That takes ten multipliers and eighteen adders per result instead of nineteen multipliers. To reach three planes ahead of and behind the centre point, the block keeps six planes of history on chip. Results leave in raster order through a ready/valid port with a flag on the last result of each volume. Volumes may follow one another without a gap or a reset.

Top module: `star19_stencil`

## Requirements
- R1: During and right after synchronous reset (`rst` high), `m_valid` and `m_last` are 0 and `s_ready` is 1.
- R2: `coefs` holds ten signed CW-bit weights in Q(FRAC) format, packed as slot k at bits [k*CW +: CW]. Slot 0 is the centre. Slots 1..3 are x at distances 1..3, slots 4..6 are y at distances 1..3 and slots 7..9 are z at distances 1..3. Each result equals the 19-term sum of weight times sample before rounding and saturation.
- R3: One result is emitted per point with x, y and z each in 3..N-4, in raster order, and nothing else. That is (NX-6)(NY-6)(NZ-6) results per volume.
- R4: `m_last` is 1 exactly with the result for point (NX-4, NY-4, NZ-4) and never while `m_valid` is 0.
- R5: While `m_valid` is 1 and `m_ready` is 0, the result and `m_last` stay unchanged, `s_ready` is 0, and no input is lost.
- R6: Whenever `m_valid` is 0 or `m_ready` is 1, `s_ready` is 1, so with `m_ready` held high the block accepts one sample per cycle.
- R7: A sum whose rounded value lies outside the DW-bit signed range is clamped to 32767 or -32768.
- R8: Rounding adds 2^(FRAC-1) and then shifts right arithmetically by FRAC. So +0.5 becomes 1 and -0.5 becomes 0.
- R9: A second volume that follows the first directly, without reset, is processed just like the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_data | input | DW | Signed input sample |
| coefs | input | 10*CW | Packed signed weights, slot layout as in R2 |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream accepts the result |
| m_data | output | DW | Rounded, saturated signed result |
| m_last | output | 1 | Last result of a volume |

## Verification
On every cycle, the assertions check four things. An output held under backpressure must stay stable. The end-of-volume flag must fall on exactly the last expected result. No result may appear before three planes have been received. The outputs must be idle just after reset. Whether each value is numerically correct, and whether rounding ties, saturation and back-to-back volumes behave as required, only the bench's scenarios can show. The bench does this by comparing every result against an unfolded 19-multiply model or against known constant answers.

// File: rtl/star19_stencil.sv
module star19_stencil #(
  parameter int NX = 12,
  parameter int NY = 12,
  parameter int NZ = 12,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FRAC = 12
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  input  logic [10*CW-1:0]     coefs,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_data,
  output logic                 m_last
);
  localparam int R = 3;
  localparam int P = NX * NY;
  localparam int C = R * P;
  localparam int DEPTH = 2 * C;
  localparam int PW = DW + CW + 1;
  localparam int AW = PW + 4;
  localparam int FW = $clog2(C + 1);
  localparam int XW = $clog2(NX);
  localparam int YW = $clog2(NY);
  localparam int ZW = $clog2(NZ);

  logic signed [DW-1:0] win [DEPTH];
  logic signed [DW-1:0] tap [DEPTH+1];
  logic signed [PW-1:0] prod [10];
  logic signed [AW-1:0] acc, sh;
  logic signed [DW-1:0] res;
  logic [FW-1:0] fill;
  logic [XW-1:0] cx;
  logic [YW-1:0] cy;
  logic [ZW-1:0] cz;
  logic take, act, inner, endpt;

  assign s_ready = !m_valid || m_ready;
  assign take = s_valid && s_ready;

  always_comb begin
    tap[0] = s_data;
    for (int i = 1; i <= DEPTH; i++) tap[i] = win[i-1];
  end

  always_ff @(posedge clk) begin
    if (take) begin
      win[0] <= s_data;
      for (int i = 1; i < DEPTH; i++) win[i] <= win[i-1];
    end
  end

  assign prod[0] = PW'(tap[C]) * PW'($signed(coefs[CW-1:0]));

  for (genvar a = 0; a < 3; a++) begin : g_ax
    for (genvar d = 1; d <= R; d++) begin : g_d
      localparam int S = (a == 0) ? 1 : ((a == 1) ? NX : P);
      localparam int K = 1 + a * R + d - 1;
      logic signed [DW:0] pr;
      assign pr = (DW+1)'(tap[C + d*S]) + (DW+1)'(tap[C - d*S]);
      assign prod[K] = PW'(pr) * PW'($signed(coefs[K*CW +: CW]));
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < 10; k++) acc = acc + AW'(prod[k]);
  end

  assign sh = (acc + AW'(1 <<< (FRAC - 1))) >>> FRAC;

  always_comb begin
    if (!sh[AW-1] && (|sh[AW-2:DW-1]))       res = {1'b0, {(DW-1){1'b1}}};
    else if (sh[AW-1] && !(&sh[AW-2:DW-1]))  res = {1'b1, {(DW-1){1'b0}}};
    else                                     res = sh[DW-1:0];
  end

  assign act = (fill == FW'(C));
  assign inner = act
    && cx >= XW'(R) && cx <= XW'(NX-1-R)
    && cy >= YW'(R) && cy <= YW'(NY-1-R)
    && cz >= ZW'(R) && cz <= ZW'(NZ-1-R);
  assign endpt = inner && cx == XW'(NX-1-R) && cy == YW'(NY-1-R) && cz == ZW'(NZ-1-R);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
      cx <= '0;
      cy <= '0;
      cz <= '0;
      m_valid <= 1'b0;
      m_last <= 1'b0;
    end else if (take) begin
      if (!act) fill <= fill + 1'b1;
      else if (cx == XW'(NX-1)) begin
        cx <= '0;
        if (cy == YW'(NY-1)) begin
          cy <= '0;
          cz <= (cz == ZW'(NZ-1)) ? '0 : cz + 1'b1;
        end else cy <= cy + 1'b1;
      end else cx <= cx + 1'b1;
      m_valid <= inner;
      m_last <= endpt;
      m_data <= res;
    end else if (m_ready) begin
      m_valid <= 1'b0;
      m_last <= 1'b0;
    end
  end
endmodule

// File: rtl/star19_chk.sv
module star19_chk #(
  parameter int NX = 12,
  parameter int NY = 12,
  parameter int NZ = 12,
  parameter int DW = 16
)(
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic          m_last,
  input logic [DW-1:0] m_data
);
  localparam int C = 3 * NX * NY;
  localparam int NOUT = (NX-6) * (NY-6) * (NZ-6);

  int seen, ocnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 0;
      ocnt <= 0;
    end else begin
      if (s_valid && s_ready && seen <= C) seen <= seen + 1;
      if (m_valid && m_ready) ocnt <= m_last ? 0 : ocnt + 1;
    end
  end

  // R1
  after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!m_valid && !m_last));

  // R3
  prime_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> seen > C);

  // R4
  last_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_last) |-> ocnt == NOUT - 1);

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

bind star19_stencil star19_chk #(.NX(NX), .NY(NY), .NZ(NZ), .DW(DW)) u_chk (.*);

// File: tb/sim_star19_stencil.sv
module sim_star19_stencil;
  localparam int CLK_T = 10;
  localparam int NX = 12, NY = 12, NZ = 12, DW = 16, CW = 16, FRAC = 12;
  localparam int NOUT = (NX-6) * (NY-6) * (NZ-6);
  localparam int LIMIT = 150000;

  logic clk = 0, rst = 1;
  logic s_valid = 0, m_ready = 0;
  logic signed [DW-1:0] s_data = '0;
  logic [10*CW-1:0] coefs = '0;
  logic s_ready, m_valid, m_last;
  logic signed [DW-1:0] m_data;

  always #(CLK_T/2) clk = ~clk;

  star19_stencil #(.NX(NX), .NY(NY), .NZ(NZ), .DW(DW), .CW(CW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .coefs(coefs), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last));

  int total = 0, bad = 0, cyc = 0;
  int inq[$];
  int exd[$];
  bit exl[$];
  int cf[10];
  int vol[NZ][NY][NX];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_coefs();
    for (int k = 0; k < 10; k++) coefs[k*CW +: CW] = CW'(cf[k]);
  endtask

  function automatic int clamp(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic rand_volume(int lo, int hi);
    for (int z = 0; z < NZ; z++)
      for (int y = 0; y < NY; y++)
        for (int x = 0; x < NX; x++) begin
          vol[z][y][x] = lo + int'($urandom_range(hi - lo));
          inq.push_back(vol[z][y][x]);
        end
    for (int z = 3; z < NZ-3; z++)
      for (int y = 3; y < NY-3; y++)
        for (int x = 3; x < NX-3; x++) begin
          longint s = longint'(cf[0]) * vol[z][y][x];
          for (int d = 1; d <= 3; d++) begin
            s += longint'(cf[d]) * vol[z][y][x-d];
            s += longint'(cf[d]) * vol[z][y][x+d];
            s += longint'(cf[3+d]) * vol[z][y-d][x];
            s += longint'(cf[3+d]) * vol[z][y+d][x];
            s += longint'(cf[6+d]) * vol[z-d][y][x];
            s += longint'(cf[6+d]) * vol[z+d][y][x];
          end
          exd.push_back(clamp((s + (64'sd1 <<< (FRAC-1))) >>> FRAC));
          exl.push_back(x == NX-4 && y == NY-4 && z == NZ-4);
        end
  endtask

  task automatic const_volume(int v, int expv);
    for (int i = 0; i < NX*NY*NZ; i++) inq.push_back(v);
    for (int i = 0; i < NOUT; i++) begin
      exd.push_back(expv);
      exl.push_back(i == NOUT-1);
    end
  endtask

  task automatic run(int gap, int stall, string tag);
    bit pst = 0;
    int pd = 0;
    bit pl = 0;
    while ((inq.size() > 0 || exd.size() > 0) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      m_ready = ($urandom_range(99) >= stall);
      if (inq.size() > 0 && $urandom_range(99) >= gap) begin
        s_valid = 1;
        s_data = DW'(inq[0]);
      end else s_valid = 0;
      #1;
      // R5 / R6: ready follows the output handshake state
      if (m_valid && !m_ready) chk(s_ready == 0, "R5", s_ready, 0);
      else chk(s_ready == 1, "R6", s_ready, 1);
      if (pst) chk(m_valid && int'(m_data) == pd && m_last == pl, "R5", int'(m_data), pd);
      if (m_valid && m_ready) begin
        if (exd.size() == 0) chk(0, "R3", int'(m_data), 0);
        else begin
          chk(int'(m_data) == exd[0], tag, int'(m_data), exd[0]);
          chk(m_last == exl[0], "R4", m_last, exl[0]);
          void'(exd.pop_front());
          void'(exl.pop_front());
        end
      end
      pst = m_valid && !m_ready;
      pd = int'(m_data);
      pl = m_last;
      if (s_valid && s_ready) void'(inq.pop_front());
    end
    @(negedge clk);
    s_valid = 0;
    m_ready = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(m_valid == 0, "R3", m_valid, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    // R1
    chk(m_valid == 0, "R1", m_valid, 0);
    chk(m_last == 0, "R1", m_last, 0);
    chk(s_ready == 1, "R1", s_ready, 1);

    // R2 R3 R4 R6: random data, full throughput
    for (int k = 0; k < 10; k++) cf[k] = int'($urandom_range(2047)) - 1024;
    set_coefs();
    rand_volume(-32768, 32767);
    run(0, 0, "R2");

    // R9 R5: two volumes back to back under gaps and backpressure
    for (int k = 0; k < 10; k++) cf[k] = int'($urandom_range(1023)) - 512;
    set_coefs();
    rand_volume(-32768, 32767);
    rand_volume(-2000, 2000);
    run(30, 30, "R9");

    // R8: ties at +0.5 and -0.5
    for (int k = 0; k < 10; k++) cf[k] = 0;
    cf[0] = 2048;
    set_coefs();
    const_volume(1, 1);
    const_volume(-1, 0);
    run(10, 10, "R8");

    // R7: clamp at both ends
    cf[0] = 32767;
    set_coefs();
    const_volume(32767, 32767);
    const_volume(-32768, -32768);
    run(0, 20, "R7");

    if (cyc >= LIMIT) chk(0, "watchdog", cyc, LIMIT);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule